// File: doc/BRIEF.md
# Resource-Shared Incremental PID Controller

This block computes one step of an incremental PID control law for a single motor channel, using only one multiplier and one adder. A small sequencer walks the shared arithmetic through the steps of the calculation. Multiplexer selects steer the operands, and a vector of ten register load enables commits each partial result. The result matches, bit for bit, what a fully parallel datapath with three multipliers and four adders would produce.

A host raises a request with the desired position, the encoder count, three signed coefficients and a pair of signed output limits. The block forms the error and weights it together with the two previous errors. It adds the weighted terms to its previous output, clamps the total to the limits, and raises an acknowledge. The acknowledge stays high until the host drops its request. The error history and the stored output advance once per completed request.

Top module: `serial_pid`

## Requirements
- R1: After reset, `ack` is 0, `u_out` is 0, `ovf` is 0, and the stored previous output and both stored past errors are 0.
- R2: The error is e(n) = `pos_des` − `pos_enc`, with both taken as signed POS_W-bit values, saturated to the signed DW-bit range (−32768..32767 at default widths).
- R3: The unbounded sum is u(n−1) + k0·e(n) + k1·e(n−1) + k2·e(n−2). Coefficients and errors are signed DW-bit values. The sum is formed in AW-bit two's complement and wraps on overflow. u(n−1) is the previous bounded output.
- R4: The sum is compared, signed, against sign-extended `up_bnd` and `lo_bnd`. Above the upper limit, `u_out` = `up_bnd` and `ovf` = 1. Below the lower limit, `u_out` = `lo_bnd` and `ovf` = 1. Otherwise `u_out` = the low DW bits of the sum and `ovf` = 0.
- R5: When `req` is sampled high while the block is idle, `ack` rises exactly 9 clock edges later, counting that sampling edge as the first. `u_out` and `ovf` already hold the new result in that cycle.
- R6: `ack` stays high for as long as `req` stays high, with no further computation. It falls on the edge after `req` is sampled low.
- R7: Changes on `req` while a computation is in progress are ignored. One request yields one result, with the same latency.
- R8: e(n−1) and e(n−2) shift, and u(n−1) is updated, only when a computation completes.
- R9: `u_out` and `ovf` keep their previous values until the cycle in which `ack` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start request (level, held until ack) |
| pos_des | input | POS_W | Desired position, signed |
| pos_enc | input | POS_W | Measured encoder count, signed |
| k0 | input | DW | Coefficient on e(n), signed |
| k1 | input | DW | Coefficient on e(n−1), signed |
| k2 | input | DW | Coefficient on e(n−2), signed |
| up_bnd | input | DW | Upper output limit, signed |
| lo_bnd | input | DW | Lower output limit, signed |
| ack | output | 1 | Result valid / completion |
| u_out | output | DW | Bounded control output, signed |
| ovf | output | 1 | Sum was clamped to a limit |

## Verification
The bench builds the block with its defaults: POS_W = 24, DW = 16 and AW = 32. At these widths position differences of ±10^6 reach the error saturation in both directions. Full-scale coefficients applied to three saturated errors push the 32-bit sum past its wrap point, so wrap and clamping are tested together. Random limits that are often smaller than the sum exercise both clamp sides. Requests that are glitched mid-computation and held after completion test the handshake against its fixed nine-edge latency.

// File: rtl/pid_pkg.sv
package pid_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ERR, ST_M0, ST_M1, ST_M2, ST_A0, ST_A1, ST_A2, ST_BND, ST_ACK
  } pid_st_e;

  localparam int NLD    = 10;
  localparam int LD_E   = 0;
  localparam int LD_P0  = 1;
  localparam int LD_P1  = 2;
  localparam int LD_P2  = 3;
  localparam int LD_S   = 4;
  localparam int LD_U   = 5;
  localparam int LD_OVF = 6;
  localparam int LD_UP  = 7;
  localparam int LD_E1  = 8;
  localparam int LD_E2  = 9;

  localparam logic [1:0] MS_E0 = 2'd0, MS_E1 = 2'd1, MS_E2 = 2'd2;
  localparam logic [1:0] AA_PD = 2'd0, AA_UP = 2'd1, AA_S = 2'd2;
  localparam logic [1:0] AB_PE = 2'd0, AB_P0 = 2'd1, AB_P1 = 2'd2, AB_P2 = 2'd3;
endpackage

// File: rtl/pid_ctrl.sv
module pid_ctrl
  import pid_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  output logic             ack,
  output logic [NLD-1:0]   ld,
  output logic [1:0]       sel_ma,
  output logic [1:0]       sel_mb,
  output logic [1:0]       sel_aa,
  output logic [1:0]       sel_ab,
  output logic             sub
);
  pid_st_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req) st_d = ST_ERR;
      ST_ERR:  st_d = ST_M0;
      ST_M0:   st_d = ST_M1;
      ST_M1:   st_d = ST_M2;
      ST_M2:   st_d = ST_A0;
      ST_A0:   st_d = ST_A1;
      ST_A1:   st_d = ST_A2;
      ST_A2:   st_d = ST_BND;
      ST_BND:  st_d = ST_ACK;
      ST_ACK:  if (!req) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ld     = '0;
    sel_ma = MS_E0;
    sel_mb = 2'd0;
    sel_aa = AA_PD;
    sel_ab = AB_PE;
    sub    = 1'b0;
    unique case (st_q)
      ST_ERR: begin sub = 1'b1; ld[LD_E] = 1'b1; end
      ST_M0:  begin sel_ma = MS_E0; sel_mb = 2'd0; ld[LD_P0] = 1'b1; end
      ST_M1:  begin sel_ma = MS_E1; sel_mb = 2'd1; ld[LD_P1] = 1'b1; end
      ST_M2:  begin sel_ma = MS_E2; sel_mb = 2'd2; ld[LD_P2] = 1'b1; end
      ST_A0:  begin sel_aa = AA_UP; sel_ab = AB_P0; ld[LD_S] = 1'b1; end
      ST_A1:  begin sel_aa = AA_S;  sel_ab = AB_P1; ld[LD_S] = 1'b1; end
      ST_A2:  begin sel_aa = AA_S;  sel_ab = AB_P2; ld[LD_S] = 1'b1; end
      ST_BND: begin
        ld[LD_U]  = 1'b1; ld[LD_OVF] = 1'b1; ld[LD_UP] = 1'b1;
        ld[LD_E1] = 1'b1; ld[LD_E2]  = 1'b1;
      end
      default: ;
    endcase
  end

  assign ack = (st_q == ST_ACK);
endmodule

// File: rtl/pid_dpath.sv
module pid_dpath
  import pid_pkg::*;
#(
  parameter int POS_W = 24,
  parameter int DW    = 16,
  parameter int AW    = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLD-1:0]    ld,
  input  logic [1:0]        sel_ma,
  input  logic [1:0]        sel_mb,
  input  logic [1:0]        sel_aa,
  input  logic [1:0]        sel_ab,
  input  logic              sub,
  input  logic [POS_W-1:0]  pos_des,
  input  logic [POS_W-1:0]  pos_enc,
  input  logic [DW-1:0]     k0,
  input  logic [DW-1:0]     k1,
  input  logic [DW-1:0]     k2,
  input  logic [DW-1:0]     up_bnd,
  input  logic [DW-1:0]     lo_bnd,
  output logic [DW-1:0]     u_out,
  output logic              ovf
);
  localparam logic signed [AW-1:0] E_MAX = AW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [AW-1:0] E_MIN = -E_MAX - AW'(1);

  function automatic logic signed [AW-1:0] sx_d(input logic [DW-1:0] v);
    return $signed({{(AW-DW){v[DW-1]}}, v});
  endfunction

  function automatic logic signed [AW-1:0] sx_p(input logic [POS_W-1:0] v);
    return $signed({{(AW-POS_W){v[POS_W-1]}}, v});
  endfunction

  function automatic logic [DW-1:0] sat_err(input logic signed [AW-1:0] v);
    if (v > E_MAX)      return E_MAX[DW-1:0];
    else if (v < E_MIN) return E_MIN[DW-1:0];
    else                return v[DW-1:0];
  endfunction

  function automatic logic [DW:0] clamp(input logic signed [AW-1:0] v,
                                        input logic [DW-1:0] hi,
                                        input logic [DW-1:0] lo);
    if (v > sx_d(hi))      return {1'b1, hi};
    else if (v < sx_d(lo)) return {1'b1, lo};
    else                   return {1'b0, v[DW-1:0]};
  endfunction

  logic [DW-1:0]        e_q, e1_q, e2_q, up_q, u_q;
  logic                 ovf_q;
  logic signed [AW-1:0] p_q [3];
  logic signed [AW-1:0] s_q;
  logic [DW-1:0]        mul_a, mul_b;
  logic signed [AW-1:0] prod, add_a, add_b, add_y;
  logic [DW:0]          bnd;

  always_comb begin
    unique case (sel_ma)
      MS_E1:   mul_a = e1_q;
      MS_E2:   mul_a = e2_q;
      default: mul_a = e_q;
    endcase
    unique case (sel_mb)
      2'd1:    mul_b = k1;
      2'd2:    mul_b = k2;
      default: mul_b = k0;
    endcase
    unique case (sel_aa)
      AA_UP:   add_a = sx_d(up_q);
      AA_S:    add_a = s_q;
      default: add_a = sx_p(pos_des);
    endcase
    unique case (sel_ab)
      AB_P0:   add_b = p_q[0];
      AB_P1:   add_b = p_q[1];
      AB_P2:   add_b = p_q[2];
      default: add_b = sx_p(pos_enc);
    endcase
  end

  assign prod  = sx_d(mul_a) * sx_d(mul_b);
  assign add_y = sub ? (add_a - add_b) : (add_a + add_b);
  assign bnd   = clamp(s_q, up_bnd, lo_bnd);

  for (genvar i = 0; i < 3; i++) begin : g_prod
    always_ff @(posedge clk) begin
      if (!rst_n)             p_q[i] <= '0;
      else if (ld[LD_P0 + i]) p_q[i] <= prod;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_q <= '0; e1_q <= '0; e2_q <= '0; s_q <= '0;
      up_q <= '0; u_q <= '0; ovf_q <= 1'b0;
    end else begin
      if (ld[LD_E])   e_q   <= sat_err(add_y);
      if (ld[LD_S])   s_q   <= add_y;
      if (ld[LD_U])   u_q   <= bnd[DW-1:0];
      if (ld[LD_OVF]) ovf_q <= bnd[DW];
      if (ld[LD_UP])  up_q  <= bnd[DW-1:0];
      if (ld[LD_E1])  e1_q  <= e_q;
      if (ld[LD_E2])  e2_q  <= e1_q;
    end
  end

  assign u_out = u_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/serial_pid.sv
module serial_pid
  import pid_pkg::*;
#(
  parameter int POS_W = 24,
  parameter int DW    = 16,
  parameter int AW    = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [POS_W-1:0] pos_des,
  input  logic [POS_W-1:0] pos_enc,
  input  logic [DW-1:0]    k0,
  input  logic [DW-1:0]    k1,
  input  logic [DW-1:0]    k2,
  input  logic [DW-1:0]    up_bnd,
  input  logic [DW-1:0]    lo_bnd,
  output logic             ack,
  output logic [DW-1:0]    u_out,
  output logic             ovf
);
  logic [NLD-1:0] ld;
  logic [1:0]     sel_ma, sel_mb, sel_aa, sel_ab;
  logic           sub;

  pid_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .ld(ld),
    .sel_ma(sel_ma), .sel_mb(sel_mb), .sel_aa(sel_aa), .sel_ab(sel_ab), .sub(sub)
  );

  pid_dpath #(.POS_W(POS_W), .DW(DW), .AW(AW)) u_dpath (
    .clk(clk), .rst_n(rst_n), .ld(ld),
    .sel_ma(sel_ma), .sel_mb(sel_mb), .sel_aa(sel_aa), .sel_ab(sel_ab), .sub(sub),
    .pos_des(pos_des), .pos_enc(pos_enc), .k0(k0), .k1(k1), .k2(k2),
    .up_bnd(up_bnd), .lo_bnd(lo_bnd), .u_out(u_out), .ovf(ovf)
  );
endmodule

// File: rtl/pid_chk.sv
module pid_chk
  import pid_pkg::*;
#(
  parameter int DW = 16
)(
  input logic           clk,
  input logic           rst_n,
  input logic           req,
  input logic           ack,
  input logic [NLD-1:0] ld,
  input logic [DW-1:0]  u_out,
  input logic [DW-1:0]  up_bnd,
  input logic [DW-1:0]  lo_bnd
);
  // R5
  ack_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(ld[LD_U]));

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req) |=> ack);

  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req) |=> !ack);

  // R4
  out_in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ($signed(lo_bnd) <= $signed(up_bnd))) |->
      (($signed(u_out) >= $signed(lo_bnd)) && ($signed(u_out) <= $signed(up_bnd))));

  // R8
  hist_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld[LD_E1] || ld[LD_E2] || ld[LD_UP]) |=> ack);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !ld[LD_U]) |=> $stable(u_out));
endmodule

bind serial_pid pid_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .ld(ld),
  .u_out(u_out), .up_bnd(up_bnd), .lo_bnd(lo_bnd)
);

// File: tb/serial_pid_bench.sv
module serial_pid_bench;
  localparam int POS_W = 24;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [POS_W-1:0] pos_des = '0, pos_enc = '0;
  logic [DW-1:0] k0 = '0, k1 = '0, k2 = '0, up_bnd = '0, lo_bnd = '0;
  logic ack, ovf;
  logic [DW-1:0] u_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_u = 0, m_e1 = 0, m_e2 = 0;

  always #10 clk = ~clk;

  serial_pid u_serial_pid (
    .clk(clk), .rst_n(rst_n), .req(req), .pos_des(pos_des), .pos_enc(pos_enc),
    .k0(k0), .k1(k1), .k2(k2), .up_bnd(up_bnd), .lo_bnd(lo_bnd),
    .ack(ack), .u_out(u_out), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int err_of(input int pd, input int p);
    int d = pd - p;
    if (d > 32767) return 32767;
    if (d < -32768) return -32768;
    return d;
  endfunction

  function automatic int wrap32(input longint v);
    return int'(v);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run_op(input int pd, input int p, input int c0, input int c1,
                        input int c2, input int hi, input int lo, input bit glitch);
    int e, s, eu, prev_u;
    bit eo;
    pos_des = POS_W'(pd); pos_enc = POS_W'(p);
    k0 = DW'(c0); k1 = DW'(c1); k2 = DW'(c2);
    up_bnd = DW'(hi); lo_bnd = DW'(lo);
    req = 1'b1;
    prev_u = m_u;
    for (int c = 0; c < 8; c++) begin
      @(posedge clk); @(negedge clk);
      if (glitch && c == 2) req = 1'b0;
      if (glitch && c == 4) req = 1'b1;
      if (c == 4) chk($signed(u_out) == prev_u, "R9 hold during compute", $signed(u_out), prev_u);
    end
    chk(ack == 1'b0, glitch ? "R7 latency with glitch" : "R5 ack not early", ack, 0);
    @(posedge clk); @(negedge clk);
    chk(ack == 1'b1, glitch ? "R7 single ack" : "R5 ack at edge 9", ack, 1);
    e = err_of(pd, p);
    s = wrap32(longint'(m_u) + longint'(c0) * e + longint'(c1) * m_e1 + longint'(c2) * m_e2);
    if (s > hi)      begin eu = hi; eo = 1'b1; end
    else if (s < lo) begin eu = lo; eo = 1'b1; end
    else             begin eu = int'($signed(16'(s))); eo = 1'b0; end
    m_e2 = m_e1; m_e1 = e; m_u = eu;
    chk($signed(u_out) == eu, "R3 R4 R8 output", $signed(u_out), eu);
    chk(ovf == eo, "R4 ovf", ovf, eo);
    @(posedge clk); @(negedge clk);
    chk(ack == 1'b1 && $signed(u_out) == eu, "R6 ack held, no recompute", ack, 1);
    req = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(ack == 1'b0, "R6 ack drop", ack, 0);
  endtask

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ack == 1'b0 && u_out == '0 && ovf == 1'b0, "R1 reset outputs", {ack, u_out, ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: zero history and zero output: zero error keeps output at 0
    run_op(500, 500, 100, -50, 25, 1000, -1000, 1'b0);
    // R2: large positive difference saturates to 32767
    run_op(600000, -400000, 1, 0, 0, 32767, -32768, 1'b0);
    // R2: large negative difference saturates to -32768, then history feeds in
    run_op(-700000, 200000, 0, 1, 0, 32767, -32768, 1'b0);
    // R4: upper clamp
    run_op(100, 0, 1000, 0, 0, 200, -200, 1'b0);
    // R4: lower clamp
    run_op(-100, 0, 1000, 0, 0, 200, -200, 1'b0);
    // R3: 32-bit wrap of three full-scale products into a negative sum
    run_op(-40000, 0, 0, 0, 0, 32767, -32768, 1'b0);
    run_op(-40000, 0, 0, 0, 0, 32767, -32768, 1'b0);
    run_op(-40000, 0, -32768, -32768, -32768, 32767, -32768, 1'b0);
    // R7: request glitch mid-computation
    run_op(1234, 1000, 3, -2, 1, 30000, -30000, 1'b1);
    // mixed random stimulus
    for (int i = 0; i < 300; i++) begin
      int pd, p, c0, c1, c2, hi, lo;
      pd = int'($urandom_range(0, 2000000)) - 1000000;
      p  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 2000000)) - 1000000
                                       : pd + int'($urandom_range(0, 400)) - 200;
      c0 = int'($urandom_range(0, 511)) - 256;
      c1 = int'($urandom_range(0, 511)) - 256;
      c2 = int'($urandom_range(0, 255)) - 128;
      if ($urandom_range(0, 9) == 0) c0 = int'($urandom_range(0, 65535)) - 32768;
      hi = int'($urandom_range(0, 32767));
      lo = -int'($urandom_range(0, 32768));
      run_op(pd, p, c0, c1, c2, hi, lo, ($urandom_range(0, 7) == 0));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule